// File: doc/BRIEF.md
# PHY Function and Interface Control Register Bank

This block keeps two 8-bit control registers of a USB transceiver behind a decoded register port. The function control register drives the transceiver speed choice, the transmit encoding mode, the termination select and two self-clearing action bits; the interface control register holds a handful of legacy interface enables. Each register has three write addresses: one replaces the value, one ORs the data in and one clears the bits that are 1 in the data. A read at any of the three addresses returns the same value.

The two action bits start hardware sequences. Setting the core-reset bit raises DIR and the core reset until the core reports completion; the bit then drops by itself, DIR falls and an RXCMD update is requested one cycle later. Clearing the suspend bit (active low) enters low-power mode; the link's STP brings the block out of it and the bit returns to 1 by itself. The core reset never touches this register bank.

Top module: `phy_ctrl_regs`

## Requirements
- R1: After reset, the function register reads 41h (SUSPENDM bit 6 = 1, XCVRSELECT bits 1:0 = 01), the interface register reads 00h, and dir, core_rst, lowpwr and rxcmd_req are 0.
- R2: Function register: a write at 04h replaces the value, at 05h ORs the data in, at 06h clears the bits set in the data; a read at 04h, 05h or 06h returns the same value.
- R3: Interface register: the same replace/set/clear scheme at 07h, 08h, 09h, with reads accepted at all three; its writable bits are 7, 6, 5, 3 and 1.
- R4: Reserved bits (function bit 7; interface bits 0, 2, 4) read 0 and ignore writes through every alias.
- R5: opmode equals function bits 4:3, term_sel bit 2, xcvr_sel bits 1:0, and ifc_mode equals the interface register.
- R6: Setting the RESET bit (bit 5) raises dir and core_rst on the next cycle; they stay high until core_done.
- R7: A core_done pulse while resetting clears RESET, dir and core_rst at that edge; rxcmd_req is then high for exactly one cycle, one cycle later. Other fields are kept. core_done while not resetting has no effect.
- R8: Register writes arriving while dir is high are ignored.
- R9: Clearing SUSPENDM raises lowpwr on the next cycle; stp while in low power drops lowpwr at the next edge and SUSPENDM reads 1 again.
- R10: When stp wakes the block in the same cycle as a write to the function register, the write is applied to all other bits and SUSPENDM still ends at 1.
- R11: Reads of unmapped addresses return 00h; writes to them change nothing.
- R12: rd_data is registered: it takes the addressed value at the edge where acc_rd is high and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| acc_addr | input | 8 | Decoded register address |
| acc_wdata | input | 8 | Write data |
| acc_wr | input | 1 | Write strobe |
| acc_rd | input | 1 | Read strobe |
| stp | input | 1 | Link stop signal, wakes from low power |
| core_done | input | 1 | Core reset completion pulse |
| rd_data | output | 8 | Registered read data |
| dir | output | 1 | Bus direction held during core reset |
| core_rst | output | 1 | Digital core reset |
| lowpwr | output | 1 | Low-power mode enable |
| rxcmd_req | output | 1 | One-cycle RXCMD update request |
| opmode | output | 2 | Transmit encoding mode |
| xcvr_sel | output | 2 | Transceiver speed select |
| term_sel | output | 1 | Termination select |
| ifc_mode | output | 8 | Interface control enables |

## Verification
The STP wake-up and a register write can land in the same cycle, both updating the function register. The bench drives a clear-alias write that removes TERMSELECT on the very cycle STP is high during low power, then checks that lowpwr falls, term_sel reads 0 and the readback shows SUSPENDM at 1. A second overlap, a write arriving while DIR is held by the reset sequence, is judged by reading the register back unchanged.

// File: rtl/phy_ctrl_regs.sv
module phy_ctrl_regs #(
  parameter int AW = 8,
  parameter logic [AW-1:0] FUNC_BASE = 8'h04,
  parameter logic [AW-1:0] IFC_BASE  = 8'h07
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] acc_addr,
  input  logic [7:0]    acc_wdata,
  input  logic          acc_wr,
  input  logic          acc_rd,
  input  logic          stp,
  input  logic          core_done,
  output logic [7:0]    rd_data,
  output logic          dir,
  output logic          core_rst,
  output logic          lowpwr,
  output logic          rxcmd_req,
  output logic [1:0]    opmode,
  output logic [1:0]    xcvr_sel,
  output logic          term_sel,
  output logic [7:0]    ifc_mode
);
  localparam logic [7:0] FUNC_MASK = 8'h7F;
  localparam logic [7:0] IFC_MASK  = 8'hEA;
  localparam logic [7:0] FUNC_RST  = 8'h41;
  localparam int SUSP_BIT = 6;
  localparam int RST_BIT  = 5;

  logic [7:0] func_q, ifc_q, func_d, ifc_d;
  logic       done_d;

  wire f_w = acc_addr == FUNC_BASE;
  wire f_s = acc_addr == FUNC_BASE + AW'(1);
  wire f_c = acc_addr == FUNC_BASE + AW'(2);
  wire i_w = acc_addr == IFC_BASE;
  wire i_s = acc_addr == IFC_BASE + AW'(1);
  wire i_c = acc_addr == IFC_BASE + AW'(2);
  wire wr_ok = acc_wr && !dir;
  wire unmapped = !(f_w || f_s || f_c || i_w || i_s || i_c);

  function automatic logic [7:0] upd(input logic [7:0] old, input logic [7:0] d,
                                     input logic w, input logic s, input logic c);
    if (w)      return d;
    else if (s) return old | d;
    else if (c) return old & ~d;
    return old;
  endfunction

  always_comb begin
    func_d = wr_ok ? (upd(func_q, acc_wdata, f_w, f_s, f_c) & FUNC_MASK) : func_q;
    if (func_q[RST_BIT] && core_done) func_d[RST_BIT] = 1'b0;
    if (!func_q[SUSP_BIT] && stp)     func_d[SUSP_BIT] = 1'b1;
    ifc_d = wr_ok ? (upd(ifc_q, acc_wdata, i_w, i_s, i_c) & IFC_MASK) : ifc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      func_q    <= FUNC_RST;
      ifc_q     <= '0;
      done_d    <= 1'b0;
      rxcmd_req <= 1'b0;
      rd_data   <= '0;
    end else begin
      func_q    <= func_d;
      ifc_q     <= ifc_d;
      done_d    <= func_q[RST_BIT] && core_done;
      rxcmd_req <= done_d;
      if (acc_rd)
        rd_data <= (f_w || f_s || f_c) ? func_q :
                   (i_w || i_s || i_c) ? ifc_q  : 8'h00;
    end
  end

  assign dir      = func_q[RST_BIT];
  assign core_rst = func_q[RST_BIT];
  assign lowpwr   = !func_q[SUSP_BIT];
  assign opmode   = func_q[4:3];
  assign term_sel = func_q[2];
  assign xcvr_sel = func_q[1:0];
  assign ifc_mode = ifc_q;

  a_r6_dir_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dir) |-> $past(acc_wr));
  a_r7_rxcmd_after_dir: assert property (@(posedge clk) disable iff (!rst_n)
    rxcmd_req |-> (!dir && $past(dir, 2)));
  a_r7_rxcmd_single: assert property (@(posedge clk) disable iff (!rst_n)
    rxcmd_req |=> !rxcmd_req);
  a_r8_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (dir && acc_wr) |=> ($stable(opmode) && $stable(xcvr_sel) && $stable(term_sel) && $stable(ifc_mode)));
  a_r9_stp_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    (lowpwr && stp) |=> !lowpwr);
  a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && unmapped) |=> (rd_data == 8'h00));
endmodule

// File: tb/tb_phy_ctrl_regs.sv
module tb_phy_ctrl_regs;
  logic clk = 0, rst_n = 0;
  logic [7:0] acc_addr = 0, acc_wdata = 0;
  logic acc_wr = 0, acc_rd = 0, stp = 0, core_done = 0;
  logic [7:0] rd_data, ifc_mode;
  logic dir, core_rst, lowpwr, rxcmd_req, term_sel;
  logic [1:0] opmode, xcvr_sel;
  int errors = 0, checks = 0;
  bit finished = 0;

  phy_ctrl_regs dut (.*);

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); acc_addr = a; acc_wdata = d; acc_wr = 1;
    @(negedge clk); acc_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); acc_addr = a; acc_rd = 1;
    @(negedge clk); acc_rd = 0;
    chk(tag, rd_data, exp);
  endtask

  task automatic t_reset;
    chk("R1 dir", dir, 0); chk("R1 core_rst", core_rst, 0);
    chk("R1 lowpwr", lowpwr, 0); chk("R1 rxcmd", rxcmd_req, 0);
    chk("R1 xcvr", xcvr_sel, 1); chk("R1 opmode", opmode, 0);
    rd(8'h04, 8'h41, "R1 func");
    rd(8'h07, 8'h00, "R1 ifc");
  endtask

  task automatic t_func_alias;
    wr(8'h04, 8'hDA);
    rd(8'h04, 8'h5A, "R2 write 04 / R4 bit7");
    rd(8'h05, 8'h5A, "R2 read 05");
    rd(8'h06, 8'h5A, "R2 read 06");
    chk("R5 opmode", opmode, 3); chk("R5 xcvr", xcvr_sel, 2); chk("R5 term", term_sel, 0);
    wr(8'h05, 8'h04);
    rd(8'h04, 8'h5E, "R2 set 05");
    wr(8'h06, 8'h18);
    rd(8'h06, 8'h46, "R2 clear 06");
    chk("R5 opmode after clear", opmode, 0); chk("R5 term after set", term_sel, 1);
    wr(8'h05, 8'h80);
    rd(8'h04, 8'h46, "R4 func reserved set");
  endtask

  task automatic t_ifc;
    wr(8'h07, 8'hFF);
    rd(8'h08, 8'hEA, "R3 write 07 / R4");
    chk("R5 ifc_mode", ifc_mode, 8'hEA);
    wr(8'h09, 8'h22);
    rd(8'h07, 8'hC8, "R3 clear 09");
    wr(8'h08, 8'h17);
    rd(8'h09, 8'hCA, "R3 set 08 / R4 reserved");
  endtask

  task automatic t_unmapped;
    wr(8'h0A, 8'hFF); wr(8'h03, 8'h00);
    rd(8'h0A, 8'h00, "R11 read 0A");
    rd(8'h00, 8'h00, "R11 read 00");
    rd(8'h04, 8'h46, "R11 func untouched");
    rd(8'h07, 8'hCA, "R11 ifc untouched");
  endtask

  task automatic t_reset_seq;
    wr(8'h05, 8'h20);
    chk("R6 dir", dir, 1); chk("R6 core_rst", core_rst, 1);
    rd(8'h04, 8'h66, "R6 reset bit");
    wr(8'h04, 8'h00);
    wr(8'h07, 8'h00);
    chk("R8 term kept", term_sel, 1); chk("R8 ifc kept", ifc_mode, 8'hCA);
    repeat (3) @(negedge clk);
    chk("R6 dir held", dir, 1);
    core_done = 1; @(negedge clk); core_done = 0;
    chk("R7 dir low", dir, 0); chk("R7 core_rst low", core_rst, 0);
    chk("R7 rxcmd not yet", rxcmd_req, 0);
    @(negedge clk); chk("R7 rxcmd pulse", rxcmd_req, 1);
    @(negedge clk); chk("R7 rxcmd single", rxcmd_req, 0);
    rd(8'h04, 8'h46, "R7 fields kept");
    core_done = 1; @(negedge clk); core_done = 0;
    @(negedge clk); chk("R7 idle done no rxcmd", rxcmd_req, 0);
    @(negedge clk); chk("R7 idle done no rxcmd2", rxcmd_req, 0);
    chk("R7 idle done no dir", dir, 0);
  endtask

  task automatic t_suspend;
    wr(8'h06, 8'h40);
    chk("R9 lowpwr on", lowpwr, 1);
    rd(8'h04, 8'h06, "R9 susp cleared");
    stp = 1; @(negedge clk); stp = 0;
    chk("R9 lowpwr off", lowpwr, 0);
    rd(8'h04, 8'h46, "R9 susp restored");
  endtask

  task automatic t_concurrent;
    wr(8'h06, 8'h40);
    @(negedge clk); acc_addr = 8'h06; acc_wdata = 8'h04; acc_wr = 1; stp = 1;
    @(negedge clk); acc_wr = 0; stp = 0;
    chk("R10 lowpwr off", lowpwr, 0); chk("R10 term cleared", term_sel, 0);
    rd(8'h04, 8'h42, "R10 readback");
  endtask

  task automatic t_rd_hold;
    rd(8'h07, 8'hCA, "R12 load");
    @(negedge clk); acc_addr = 8'h04;
    @(negedge clk); chk("R12 hold", rd_data, 8'hCA);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset(); t_func_alias(); t_ifc(); t_unmapped();
    t_reset_seq(); t_suspend(); t_concurrent(); t_rd_hold();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule